// File: doc/BRIEF.md
# Receive Word Deserializer with Comma Alignment

This block sits behind a serial-link character decoder. Every character-clock cycle it takes one 10-bit character, made of an 8-bit data byte and two side bits, together with a comma flag from the decoder. It collects four consecutive characters into one 32-bit word. Bit 8 and bit 9 of the four characters leave the block as two 4-bit side vectors. The block also outputs a 4-bit comma position vector and a single-cycle word strobe.

Once the link reports synchronization, the block moves its four-character boundary so that a comma opens the next word in the most significant byte, which is the only byte a downstream lane aligner inspects. Three events arm a fresh boundary search: the first rising edge of the sync input, any later return of sync after a loss, and a 0-to-1 transition of the realign request. While sync is low, words keep leaving on whatever boundary is in force. A level-sensitive hold input freezes the boundary completely.

Top module: `rxw_deser`

## Requirements
- R1: One character is accepted on every clock edge. The clock edge that accepts the fourth character of a word raises word_valid_o for exactly one cycle. At all other times word_valid_o is 0.
- R2: The first character of a word appears in word_o[31:24], the second in [23:16], the third in [15:8] and the last in [7:0]. Each byte is char_i[7:0] of that character.
- R3: bit8_o and bit9_o carry char_i[8] and char_i[9] of each character in the same order as word_o. Index 3 holds the first character and index 0 holds the last.
- R4: While sync_i is 1, hold_i is 0 and a search is pending, the first character that arrives with comma_i = 1 restarts the word. That character becomes byte [31:24] of the next emitted word, and the characters already collected are discarded.
- R5: A search becomes pending on a rising edge of sync_i or on a rising edge of realign_i, and it ends when an alignment takes place. Holding realign_i at 1 does not start any further search.
- R6: While sync_i is 0, no alignment takes place. Words continue to be emitted every four characters on the current boundary.
- R7: While hold_i is 1, commas never move the boundary. A search that is pending stays pending and is carried out once hold_i returns to 0.
- R8: comma_pos_o[3-k] is 1 only when character k of the word carried comma_i = 1 and sync_i was 1 both when that character arrived and when the last character of the word arrived. In every other case the bit is 0, including words completed while sync_i is low.
- R9: A comma that arrives while no search is pending does not move the boundary. It is only reported in comma_pos_o.
- R10: Asserting rst_ni low clears word_o, the side vectors, comma_pos_o, word_valid_o and the character count. After reset no search is pending until the first rising edge of sync_i or realign_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_i | input | 10 | Received character: data in [7:0], side bits in [9:8] |
| comma_i | input | 1 | Decoder flags the current character as a comma |
| sync_i | input | 1 | Link synchronized |
| realign_i | input | 1 | A 0-to-1 transition requests a new comma search |
| hold_i | input | 1 | While 1, the word boundary is frozen |
| word_o | output | 32 | Assembled data word, first character in the top byte |
| bit8_o | output | 4 | Bit 8 of each character, in word byte order |
| bit9_o | output | 4 | Bit 9 of each character, in word byte order |
| comma_pos_o | output | 4 | Byte positions in the word that held a comma while synchronized |
| word_valid_o | output | 1 | One-cycle strobe for each new word |

## Verification
The stimulus moves through five regimes:
- Unsynchronized traffic with a stray comma shows that the boundary stays fixed and that the comma flags stay at zero.
- A sync rising edge followed by a mid-word comma shows that the partial word is dropped and that the comma lands in the top byte.
- A comma with no search pending, and a realign input that stays high, show that only edges arm a search.
- Commas under hold show that the boundary is frozen while the pending search survives until hold is released.
- A sync drop and return shows that the search re-arms by itself.

Directed cases then check the full byte and side-bit ordering, a reset that interrupts a partial word, and flag clearing when sync falls on the last character of a word.

// File: rtl/rxw_pkg.sv
`timescale 1ns/1ps
package rxw_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CHAR_W = DATA_W + 2;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              b8;
    logic              b9;
    logic              cm;
  } slot_t;
endpackage

// File: rtl/rxw_align_ctrl.sv
`timescale 1ns/1ps
module rxw_align_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic realign_i,
  input  logic hold_i,
  input  logic comma_i,
  output logic restart_o
);
  logic sync_q, realign_q, armed_q;
  logic sync_rise, realign_rise, pending;

  assign sync_rise    = sync_i & ~sync_q;
  assign realign_rise = realign_i & ~realign_q;
  // search stays pending across hold and sync loss until a comma is taken
  assign pending      = armed_q | sync_rise | realign_rise;
  assign restart_o    = pending & sync_i & ~hold_i & comma_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 1'b0;
      realign_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      sync_q    <= sync_i;
      realign_q <= realign_i;
      armed_q   <= pending & ~restart_o;
    end
  end
endmodule

// File: rtl/rxw_accum.sv
`timescale 1ns/1ps
module rxw_accum
  import rxw_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CHAR_W-1:0]       char_i,
  input  logic                    comma_i,
  input  logic                    sync_i,
  input  logic                    restart_i,
  output logic [LANES*DATA_W-1:0] word_o,
  output logic [LANES-1:0]        bit8_o,
  output logic [LANES-1:0]        bit9_o,
  output logic [LANES-1:0]        comma_pos_o,
  output logic                    word_valid_o
);
  localparam int unsigned CNT_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LANES - 1);

  slot_t             slots_q [LANES];
  slot_t             in_slot;
  logic [CNT_W-1:0]  cnt_q, idx;
  logic              last;

  logic [LANES*DATA_W-1:0] word_d;
  logic [LANES-1:0]        b8_d, b9_d, cpos_d;

  assign in_slot = '{data: char_i[DATA_W-1:0], b8: char_i[DATA_W],
                     b9: char_i[DATA_W+1], cm: comma_i & sync_i};
  assign idx  = restart_i ? '0 : cnt_q;
  assign last = (idx == LAST_IDX);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    slot_t src;
    if (k == LANES - 1) begin : g_tail
      assign src = in_slot;
    end else begin : g_head
      assign src = slots_q[k];
    end
    assign word_d[(LANES-1-k)*DATA_W +: DATA_W] = src.data;
    assign b8_d[LANES-1-k]   = src.b8;
    assign b9_d[LANES-1-k]   = src.b9;
    assign cpos_d[LANES-1-k] = src.cm & sync_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      for (int i = 0; i < LANES; i++) slots_q[i] <= '0;
      word_o       <= '0;
      bit8_o       <= '0;
      bit9_o       <= '0;
      comma_pos_o  <= '0;
      word_valid_o <= 1'b0;
    end else begin
      slots_q[idx] <= in_slot;
      cnt_q        <= last ? '0 : CNT_W'(idx + 1'b1);
      word_valid_o <= last;
      if (last) begin
        word_o      <= word_d;
        bit8_o      <= b8_d;
        bit9_o      <= b9_d;
        comma_pos_o <= cpos_d;
      end
    end
  end
endmodule

// File: rtl/rxw_deser.sv
`timescale 1ns/1ps
module rxw_deser
  import rxw_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CHAR_W-1:0]       char_i,
  input  logic                    comma_i,
  input  logic                    sync_i,
  input  logic                    realign_i,
  input  logic                    hold_i,
  output logic [LANES*DATA_W-1:0] word_o,
  output logic [LANES-1:0]        bit8_o,
  output logic [LANES-1:0]        bit9_o,
  output logic [LANES-1:0]        comma_pos_o,
  output logic                    word_valid_o
);
  logic restart;

  rxw_align_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .realign_i (realign_i),
    .hold_i    (hold_i),
    .comma_i   (comma_i),
    .restart_o (restart)
  );

  rxw_accum #(.LANES(LANES)) i_accum (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .char_i       (char_i),
    .comma_i      (comma_i),
    .sync_i       (sync_i),
    .restart_i    (restart),
    .word_o       (word_o),
    .bit8_o       (bit8_o),
    .bit9_o       (bit9_o),
    .comma_pos_o  (comma_pos_o),
    .word_valid_o (word_valid_o)
  );
endmodule

// File: rtl/rxw_deser_chk.sv
`timescale 1ns/1ps
module rxw_deser_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             hold_i,
  input logic             word_valid_o,
  input logic [LANES-1:0] comma_pos_o
);
  logic [3:0] gap_q;
  logic       all_hold_q, all_low_q, have_prev_q;

  // cycles since last strobe, and whether hold / no-sync covered the whole window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '0;
      all_hold_q  <= 1'b0;
      all_low_q   <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (word_valid_o) begin
      gap_q       <= 4'd1;
      all_hold_q  <= hold_i;
      all_low_q   <= ~sync_i;
      have_prev_q <= 1'b1;
    end else begin
      gap_q      <= (gap_q == 4'hF) ? gap_q : gap_q + 4'd1;
      all_hold_q <= all_hold_q & hold_i;
      all_low_q  <= all_low_q & ~sync_i;
    end
  end

  assert_valid_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  assert_nosync_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && have_prev_q && all_low_q) |-> (32'(gap_q) == LANES));

  assert_hold_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && have_prev_q && all_hold_q) |-> (32'(gap_q) == LANES));

  assert_cpos_nosync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !$past(sync_i)) |-> (comma_pos_o == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R10: assert (!word_valid_o && comma_pos_o == '0);
    end
  end
endmodule

bind rxw_deser rxw_deser_chk #(.LANES(LANES)) i_rxw_deser_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_i       (sync_i),
  .hold_i       (hold_i),
  .word_valid_o (word_valid_o),
  .comma_pos_o  (comma_pos_o)
);

// File: tb/test_rxw_deser.sv
`timescale 1ns/1ps
module test_rxw_deser;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  char_i = '0;
  logic        comma_i = 1'b0, sync_i = 1'b0, realign_i = 1'b0, hold_i = 1'b0;
  logic [31:0] word_o;
  logic [3:0]  bit8_o, bit9_o, comma_pos_o;
  logic        word_valid_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  rxw_deser i_rxw_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .char_i(char_i), .comma_i(comma_i),
    .sync_i(sync_i), .realign_i(realign_i), .hold_i(hold_i),
    .word_o(word_o), .bit8_o(bit8_o), .bit9_o(bit9_o),
    .comma_pos_o(comma_pos_o), .word_valid_o(word_valid_o)
  );

  // vector: sync, realign, hold, comma, data, exp_valid, exp_msb, exp_cpos
  function automatic logic [24:0] v(input logic s, r, h, c, input logic [7:0] d,
                                    input logic ev, input logic [7:0] em,
                                    input logic [3:0] ec);
    return {s, r, h, c, d, ev, em, ec};
  endfunction

  localparam int NV = 37;
  localparam logic [24:0] VEC [NV] = '{
    v(0,0,0,0,8'h10,0,8'h00,4'h0), v(0,0,0,0,8'h11,0,8'h00,4'h0),
    v(0,0,0,0,8'h12,0,8'h00,4'h0), v(0,0,0,0,8'h13,1,8'h10,4'h0),  // R6
    v(0,0,0,1,8'h14,0,8'h00,4'h0), v(0,0,0,0,8'h15,0,8'h00,4'h0),
    v(0,0,0,0,8'h16,0,8'h00,4'h0), v(0,0,0,0,8'h17,1,8'h14,4'h0),  // R6 R8
    v(1,0,0,0,8'h18,0,8'h00,4'h0), v(1,0,0,1,8'h19,0,8'h00,4'h0),  // R4 R5
    v(1,0,0,0,8'h1A,0,8'h00,4'h0), v(1,0,0,0,8'h1B,0,8'h00,4'h0),
    v(1,0,0,0,8'h1C,1,8'h19,4'h8),
    v(1,0,0,0,8'h1D,0,8'h00,4'h0), v(1,0,0,1,8'h1E,0,8'h00,4'h0),  // R9
    v(1,0,0,0,8'h1F,0,8'h00,4'h0), v(1,0,0,0,8'h20,1,8'h1D,4'h4),
    v(1,1,0,0,8'h21,0,8'h00,4'h0), v(1,1,0,1,8'h22,0,8'h00,4'h0),  // R5
    v(1,0,0,0,8'h23,0,8'h00,4'h0), v(1,0,0,0,8'h24,0,8'h00,4'h0),
    v(1,0,0,0,8'h25,1,8'h22,4'h8),
    v(0,0,0,0,8'h26,0,8'h00,4'h0), v(1,0,1,1,8'h27,0,8'h00,4'h0),  // R7
    v(1,0,1,0,8'h28,0,8'h00,4'h0), v(1,0,1,0,8'h29,1,8'h26,4'h4),
    v(1,0,0,0,8'h2A,0,8'h00,4'h0), v(1,0,0,1,8'h2B,0,8'h00,4'h0),  // R7
    v(1,0,0,0,8'h2C,0,8'h00,4'h0), v(1,0,0,0,8'h2D,0,8'h00,4'h0),
    v(1,0,0,0,8'h2E,1,8'h2B,4'h8),
    v(0,0,0,1,8'h2F,0,8'h00,4'h0), v(1,0,0,0,8'h30,0,8'h00,4'h0),  // R5
    v(1,0,0,1,8'h31,0,8'h00,4'h0), v(1,0,0,0,8'h32,0,8'h00,4'h0),
    v(1,0,0,0,8'h33,0,8'h00,4'h0), v(1,0,0,0,8'h34,1,8'h31,4'h8)
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply one character; returns at the next falling edge
  task automatic push(input logic s, r, h, c, input logic [9:0] ch);
    sync_i = s; realign_i = r; hold_i = h; comma_i = c; char_i = ch;
    @(negedge clk_i);
  endtask

  function automatic logic [9:0] mk(input logic [7:0] d);
    return {d[1], d[0], d};
  endfunction

  initial begin
    #(5.0 * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(word_valid_o == 1'b0, "R10 reset valid", 32'(word_valid_o), 32'h0);
    check(word_o == '0, "R10 reset word", word_o, 32'h0);
    check({bit8_o, bit9_o, comma_pos_o} == '0, "R10 reset flags",
          32'({bit8_o, bit9_o, comma_pos_o}), 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [24:0] e;
      e = VEC[i];
      push(e[24], e[23], e[22], e[21], mk(e[20:13]));
      check(word_valid_o == e[12], "R1 strobe", 32'(word_valid_o), 32'(e[12]));
      if (e[12]) begin
        check(word_o[31:24] == e[11:4], "R4/R5/R6/R7/R9 boundary",
              32'(word_o[31:24]), 32'(e[11:4]));
        check(comma_pos_o == e[3:0], "R8 comma flags", 32'(comma_pos_o), 32'(e[3:0]));
      end
    end

    // R2 R3: byte and side-bit order
    push(1, 0, 0, 0, {1'b1, 1'b0, 8'hC1});
    push(1, 0, 0, 0, {1'b0, 1'b1, 8'hC2});
    push(1, 0, 0, 0, {1'b1, 1'b1, 8'hC3});
    push(1, 0, 0, 0, {1'b0, 1'b0, 8'hC4});
    check(word_valid_o && word_o == 32'hC1C2C3C4, "R2 byte order", word_o, 32'hC1C2C3C4);
    check(bit8_o == 4'b0110, "R3 bit8 order", 32'(bit8_o), 32'h6);
    check(bit9_o == 4'b1010, "R3 bit9 order", 32'(bit9_o), 32'hA);

    // R5: realign held high only acts once
    push(1, 1, 0, 0, mk(8'hD0));
    push(1, 1, 0, 1, mk(8'hD1));
    push(1, 1, 0, 0, mk(8'hD2));
    push(1, 1, 0, 1, mk(8'hD3));
    push(1, 1, 0, 0, mk(8'hD4));
    check(word_valid_o && word_o == 32'hD1D2D3D4, "R5 level realign", word_o, 32'hD1D2D3D4);
    check(comma_pos_o == 4'b1010, "R8 two commas", 32'(comma_pos_o), 32'hA);

    // R10: reset drops the partial word and the count
    push(1, 0, 0, 0, mk(8'hE8));
    push(1, 0, 0, 0, mk(8'hE9));
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(word_valid_o == 1'b0 && word_o == '0, "R10 mid reset", word_o, 32'h0);
    rst_ni = 1'b1;
    push(1, 0, 0, 0, mk(8'hE0));
    push(1, 0, 0, 0, mk(8'hE1));
    push(1, 0, 0, 0, mk(8'hE2));
    check(word_valid_o == 1'b0, "R10 count cleared", 32'(word_valid_o), 32'h0);
    push(1, 0, 0, 0, mk(8'hE3));
    check(word_valid_o && word_o == 32'hE0E1E2E3, "R10 fresh word", word_o, 32'hE0E1E2E3);

    // R8: sync dropping on the last character clears all flags
    push(1, 0, 0, 1, mk(8'hF0));
    push(1, 0, 0, 0, mk(8'hF1));
    push(1, 0, 0, 0, mk(8'hF2));
    push(0, 0, 0, 0, mk(8'hF3));
    check(word_valid_o && word_o == 32'hF0F1F2F3, "R4 after reset", word_o, 32'hF0F1F2F3);
    check(comma_pos_o == 4'h0, "R8 sync lost", 32'(comma_pos_o), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule